// File: doc/BRIEF.md
# Interrupt Cause Aggregator

This block holds a register of pending interrupt causes, by default 32 bits wide. Internal event sources set bits in it, and software can set or clear bits through a small register window. Each source presents a one-cycle raise strobe together with a mask of the cause bits it wants to set. By convention, completion of the arithmetic engine uses bit 0 and completion of a memory copy uses bit 8. Software sets bits by writing a mask to one offset and clears bits by writing a mask to a second offset. The current cause value can be read back combinationally at a third offset.

A mode input selects how the interrupt is signalled. In level mode, a single line is held high while causes are pending. In message mode, the block instead emits a one-cycle pulse that a downstream message engine turns into a transaction. The level line only falls while level mode is selected. A line that was high when the mode switched to messages therefore stays high until level mode returns with no causes pending.

Top module: `irq_agg`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the cause register is zero and both `irq_level` and `msg_pulse` are low.
- R2: A raise ORs its mask into the cause register on the next clock edge. Raises come from any source strobe (`src_raise[i]` with `src_mask` slice i) or from a write at offset 0x60.
- R3: A write at offset 0x64 clears the written bits of the cause register on the next clock edge and leaves all other bits unchanged.
- R4: When a clear and raises arrive in the same cycle, the clear is applied first and the raises second, so a bit in both masks ends up set.
- R5: `rd_data` returns the cause register when `rd_addr` equals 0x24, and all ones for any other offset.
- R6: With `msg_en` high, a cycle containing at least one raise that leaves the cause register nonzero produces exactly one `msg_pulse` cycle on the following cycle. This holds however many sources raise in that cycle. In all other cycles `msg_pulse` is low.
- R7: With `msg_en` low, a raise that leaves the cause register nonzero drives `irq_level` high on the next cycle.
- R8: `irq_level` falls only when the cause register becomes zero while `msg_en` is low. In message mode it holds its value, even when the cause register is cleared to zero.
- R9: A raise whose result is a zero cause register (mask zero onto a zero register) produces neither a pulse nor a rising level.
- R10: Writes to offsets other than 0x60 and 0x64, including 0x24, leave the cause register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_en | input | 1 | 1 selects message pulses, 0 selects the level line |
| src_raise | input | N_SRC | One raise strobe per internal source |
| src_mask | input | N_SRC*CAUSE_W | Cause mask per source, source i in slice i |
| wr_en | input | 1 | Software write strobe |
| wr_addr | input | ADDR_W | Software write offset |
| wr_data | input | CAUSE_W | Software write mask |
| rd_addr | input | ADDR_W | Software read offset |
| rd_data | output | CAUSE_W | Read data, combinational |
| cause | output | CAUSE_W | Current cause register |
| irq_level | output | 1 | Level interrupt line |
| msg_pulse | output | 1 | One-cycle message request |

## Verification
The cause register, the level line and the pulse are all registered. Each one therefore reflects a stimulus exactly one clock edge after the cycle in which the stimulus is presented. `rd_data` follows the cause register within the same cycle. The bench drives every vector on a falling edge and checks all results on the following falling edge, so exactly one rising edge lies between stimulus and sample. Each vector states its expected cause, level and pulse for that single cycle. A pulse that lasts a second cycle is therefore caught by the idle vector that follows it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // Kind of software access decoded from one write
   typedef enum logic [1:0] {
      SW_NONE  = 2'd0,
      SW_RAISE = 2'd1,
      SW_CLEAR = 2'd2
   } sw_op_e;

   // Conventional cause bit positions for the two internal events
   localparam int unsigned CAUSE_BIT_ARITH = 0;
   localparam int unsigned CAUSE_BIT_COPY  = 8;

   // Clear first, then raise: a new event always survives
   function automatic logic [63:0] apply_cause(input logic [63:0] cur,
                                               input logic [63:0] clr,
                                               input logic [63:0] set);
      return (cur & ~clr) | set;
   endfunction

endpackage

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
   parameter int unsigned CAUSE_W = 32,
   parameter int unsigned N_SRC   = 2
) (
   input  logic [N_SRC-1:0]         src_raise,
   input  logic [N_SRC*CAUSE_W-1:0] src_mask,
   input  logic                     sw_raise,
   input  logic [CAUSE_W-1:0]       sw_mask,
   output logic [CAUSE_W-1:0]       set_mask,
   output logic                     raise_evt
);
   localparam int unsigned STAGES = N_SRC + 1;

   logic [CAUSE_W-1:0] acc [STAGES];

   assign acc[0] = sw_raise ? sw_mask : '0;

   // One OR stage per source, masked by its own strobe
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic [CAUSE_W-1:0] gated;
      assign gated      = src_raise[i] ? src_mask[i*CAUSE_W +: CAUSE_W] : '0;
      assign acc[i + 1] = acc[i] | gated;
   end

   assign set_mask  = acc[STAGES-1];
   assign raise_evt = sw_raise | (|src_raise);

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_agg_pkg::*;
#(
   parameter int unsigned CAUSE_W   = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned OFS_CAUSE = 'h24,
   parameter int unsigned OFS_RAISE = 'h60,
   parameter int unsigned OFS_CLEAR = 'h64,
   parameter bit          MISS_ONES = 1'b1
) (
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [CAUSE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic [CAUSE_W-1:0] cause_q,
   output logic               sw_raise,
   output logic               sw_clear,
   output logic [CAUSE_W-1:0] sw_mask,
   output logic [CAUSE_W-1:0] rd_data
);
   localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
   localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(OFS_RAISE);
   localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);

   sw_op_e op;

   always_comb begin
      op = SW_NONE;
      if (wr_en) begin
         if (wr_addr == A_RAISE)      op = SW_RAISE;
         else if (wr_addr == A_CLEAR) op = SW_CLEAR;
      end
   end

   assign sw_raise = (op == SW_RAISE);
   assign sw_clear = (op == SW_CLEAR);
   assign sw_mask  = wr_data;

   // Value returned for an unmapped read offset
   logic [CAUSE_W-1:0] miss_val;
   if (MISS_ONES) begin : g_miss_ones
      assign miss_val = '1;
   end else begin : g_miss_zero
      assign miss_val = '0;
   end

   assign rd_data = (rd_addr == A_CAUSE) ? cause_q : miss_val;

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
   import irq_agg_pkg::*;
#(
   parameter int unsigned CAUSE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAUSE_W-1:0] set_mask,
   input  logic               clr_en,
   input  logic [CAUSE_W-1:0] clr_mask,
   output logic [CAUSE_W-1:0] cause_next,
   output logic [CAUSE_W-1:0] cause_q
);
   logic [63:0] wide_next;
   logic [CAUSE_W-1:0] clr_eff;

   assign clr_eff    = clr_en ? clr_mask : '0;
   assign wide_next  = apply_cause(64'(cause_q), 64'(clr_eff), 64'(set_mask));
   assign cause_next = wide_next[CAUSE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= cause_next;
   end

endmodule

// File: rtl/irq_notify.sv
module irq_notify #(
   parameter int unsigned CAUSE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               msg_en,
   input  logic               raise_evt,
   input  logic [CAUSE_W-1:0] cause_next,
   output logic               irq_level,
   output logic               msg_pulse
);
   logic pending;
   logic level_set;
   logic level_rel;

   assign pending   = |cause_next;
   assign level_set = !msg_en && raise_evt && pending;
   assign level_rel = !msg_en && !pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_level <= 1'b0;
         msg_pulse <= 1'b0;
      end else begin
         msg_pulse <= msg_en && raise_evt && pending;
         if (level_set)      irq_level <= 1'b1;
         else if (level_rel) irq_level <= 1'b0;
      end
   end

endmodule

// File: rtl/irq_agg.sv
module irq_agg #(
   parameter int unsigned CAUSE_W   = 32,
   parameter int unsigned N_SRC     = 2,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned OFS_CAUSE = 'h24,
   parameter int unsigned OFS_RAISE = 'h60,
   parameter int unsigned OFS_CLEAR = 'h64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     msg_en,
   input  logic [N_SRC-1:0]         src_raise,
   input  logic [N_SRC*CAUSE_W-1:0] src_mask,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [CAUSE_W-1:0]       wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [CAUSE_W-1:0]       rd_data,
   output logic [CAUSE_W-1:0]       cause,
   output logic                     irq_level,
   output logic                     msg_pulse
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   // Elaboration-time parameter checks
   if (CAUSE_W < 1 || CAUSE_W > 64) begin : g_bad_width
      $error("irq_agg: CAUSE_W must lie in 1..64");
   end
   if (N_SRC < 1) begin : g_bad_src
      $error("irq_agg: N_SRC must be at least 1");
   end
   if (OFS_CAUSE >= ADDR_SPAN || OFS_RAISE >= ADDR_SPAN || OFS_CLEAR >= ADDR_SPAN) begin : g_bad_ofs
      $error("irq_agg: an offset does not fit in ADDR_W bits");
   end
   if (OFS_RAISE == OFS_CLEAR) begin : g_bad_alias
      $error("irq_agg: raise and clear offsets must differ");
   end

   logic               sw_raise;
   logic               sw_clear;
   logic [CAUSE_W-1:0] sw_mask;
   logic [CAUSE_W-1:0] set_mask;
   logic               raise_evt;
   logic [CAUSE_W-1:0] cause_next;
   logic [CAUSE_W-1:0] cause_q;

   irq_reg_port #(
      .CAUSE_W  (CAUSE_W),
      .ADDR_W   (ADDR_W),
      .OFS_CAUSE(OFS_CAUSE),
      .OFS_RAISE(OFS_RAISE),
      .OFS_CLEAR(OFS_CLEAR),
      .MISS_ONES(1'b1)
   ) u_port (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .cause_q (cause_q),
      .sw_raise(sw_raise),
      .sw_clear(sw_clear),
      .sw_mask (sw_mask),
      .rd_data (rd_data)
   );

   irq_src_merge #(
      .CAUSE_W(CAUSE_W),
      .N_SRC  (N_SRC)
   ) u_merge (
      .src_raise(src_raise),
      .src_mask (src_mask),
      .sw_raise (sw_raise),
      .sw_mask  (sw_mask),
      .set_mask (set_mask),
      .raise_evt(raise_evt)
   );

   irq_cause_reg #(
      .CAUSE_W(CAUSE_W)
   ) u_cause (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_mask  (set_mask),
      .clr_en    (sw_clear),
      .clr_mask  (sw_mask),
      .cause_next(cause_next),
      .cause_q   (cause_q)
   );

   irq_notify #(
      .CAUSE_W(CAUSE_W)
   ) u_notify (
      .clk       (clk),
      .rst_n     (rst_n),
      .msg_en    (msg_en),
      .raise_evt (raise_evt),
      .cause_next(cause_next),
      .irq_level (irq_level),
      .msg_pulse (msg_pulse)
   );

   assign cause = cause_q;

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
   parameter int unsigned CAUSE_W   = 32,
   parameter int unsigned N_SRC     = 2,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned OFS_RAISE = 'h60,
   parameter int unsigned OFS_CLEAR = 'h64
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     msg_en,
   input logic [N_SRC-1:0]         src_raise,
   input logic [N_SRC*CAUSE_W-1:0] src_mask,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        wr_addr,
   input logic [CAUSE_W-1:0]       wr_data,
   input logic [CAUSE_W-1:0]       cause,
   input logic                     irq_level,
   input logic                     msg_pulse
);
   logic [CAUSE_W-1:0] exp_set;
   logic [CAUSE_W-1:0] exp_clr;
   logic               any_raise;

   always_comb begin
      exp_set   = '0;
      any_raise = 1'b0;
      for (int i = 0; i < int'(N_SRC); i++) begin
         if (src_raise[i]) begin
            exp_set   = exp_set | src_mask[i*CAUSE_W +: CAUSE_W];
            any_raise = 1'b1;
         end
      end
      if (wr_en && wr_addr == ADDR_W'(OFS_RAISE)) begin
         exp_set   = exp_set | wr_data;
         any_raise = 1'b1;
      end
      exp_clr = (wr_en && wr_addr == ADDR_W'(OFS_CLEAR)) ? wr_data : '0;
   end

   assert_reset_clean_R1: assert property (@(posedge clk)
      !rst_n |=> (cause == '0 && !irq_level && !msg_pulse));

   assert_raise_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause & $past(exp_set)) == $past(exp_set)));

   assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause & $past(exp_clr & ~exp_set)) == '0));

   assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      msg_pulse |-> (cause != '0 && $past(msg_en) && $past(any_raise)));

   assert_level_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_level) |-> (cause == '0 && $past(!msg_en)));

   assert_level_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_en |=> (cause != '0 || !irq_level));

endmodule

bind irq_agg irq_agg_chk #(
   .CAUSE_W  (CAUSE_W),
   .N_SRC    (N_SRC),
   .ADDR_W   (ADDR_W),
   .OFS_RAISE(OFS_RAISE),
   .OFS_CLEAR(OFS_CLEAR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .msg_en   (msg_en),
   .src_raise(src_raise),
   .src_mask (src_mask),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .cause    (cause),
   .irq_level(irq_level),
   .msg_pulse(msg_pulse)
);

// File: tb/tb_irq_agg.sv
`timescale 1ns/1ps
module tb_irq_agg;
   localparam int W  = 32;
   localparam int NS = 2;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          msg_en = 1'b0;
   logic [NS-1:0] src_raise = '0;
   logic [NS*W-1:0] src_mask = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [AW-1:0] rd_addr = 8'h24;
   logic [W-1:0]  rd_data;
   logic [W-1:0]  cause;
   logic          irq_level;
   logic          msg_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_agg dut (
      .clk(clk), .rst_n(rst_n), .msg_en(msg_en), .src_raise(src_raise),
      .src_mask(src_mask), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cause(cause),
      .irq_level(irq_level), .msg_pulse(msg_pulse)
   );

   typedef struct packed {
      logic [1:0]  raise;
      logic [31:0] m0;
      logic [31:0] m1;
      logic        we;
      logic [7:0]  wa;
      logic [31:0] wd;
      logic        msg;
      logic [31:0] ec;
      logic        el;
      logic        ep;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      // R7: source 0 raises bit 0 in level mode
      '{2'b01, 32'h1, 32'h0, 1'b0, 8'h00, 32'h0, 1'b0, 32'h1, 1'b1, 1'b0, 8'd7},
      // R2: source 1 raises bit 8
      '{2'b10, 32'h0, 32'h100, 1'b0, 8'h00, 32'h0, 1'b0, 32'h101, 1'b1, 1'b0, 8'd2},
      // R3: clear bit 0, level holds
      '{2'b00, 32'h0, 32'h0, 1'b1, 8'h64, 32'h1, 1'b0, 32'h100, 1'b1, 1'b0, 8'd3},
      // R8: clear last bit in level mode drops level
      '{2'b00, 32'h0, 32'h0, 1'b1, 8'h64, 32'h100, 1'b0, 32'h0, 1'b0, 1'b0, 8'd8},
      // R6: two sources together, one pulse
      '{2'b11, 32'h1, 32'h100, 1'b0, 8'h00, 32'h0, 1'b1, 32'h101, 1'b0, 1'b1, 8'd6},
      // R6: idle cycle, pulse gone
      '{2'b00, 32'h0, 32'h0, 1'b0, 8'h00, 32'h0, 1'b1, 32'h101, 1'b0, 1'b0, 8'd6},
      // R2: software raise at 0x60 in message mode
      '{2'b00, 32'h0, 32'h0, 1'b1, 8'h60, 32'h8000_0000, 1'b1, 32'h8000_0101, 1'b0, 1'b1, 8'd2},
      // R6: clear all, no pulse
      '{2'b00, 32'h0, 32'h0, 1'b1, 8'h64, 32'hFFFF_FFFF, 1'b1, 32'h0, 1'b0, 1'b0, 8'd6},
      // R7: software raise in level mode
      '{2'b00, 32'h0, 32'h0, 1'b1, 8'h60, 32'h10, 1'b0, 32'h10, 1'b1, 1'b0, 8'd7},
      // R8: clear to zero in message mode keeps level
      '{2'b00, 32'h0, 32'h0, 1'b1, 8'h64, 32'h10, 1'b1, 32'h0, 1'b1, 1'b0, 8'd8},
      // R8: still held in message mode
      '{2'b00, 32'h0, 32'h0, 1'b0, 8'h00, 32'h0, 1'b1, 32'h0, 1'b1, 1'b0, 8'd8},
      // R8: back to level mode with zero causes releases
      '{2'b00, 32'h0, 32'h0, 1'b0, 8'h00, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 8'd8},
      // R9: zero-mask raise in level mode
      '{2'b01, 32'h0, 32'h0, 1'b0, 8'h00, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 8'd9},
      // R9: zero-mask raise in message mode
      '{2'b01, 32'h0, 32'h0, 1'b0, 8'h00, 32'h0, 1'b1, 32'h0, 1'b0, 1'b0, 8'd9},
      // R10: write to read offset 0x24 ignored
      '{2'b00, 32'h0, 32'h0, 1'b1, 8'h24, 32'hFFFF, 1'b0, 32'h0, 1'b0, 1'b0, 8'd10},
      // R2: software raise of four bits
      '{2'b00, 32'h0, 32'h0, 1'b1, 8'h60, 32'hF, 1'b0, 32'hF, 1'b1, 1'b0, 8'd2},
      // R4: clear 0x3 with source raise of bit 0 in same cycle
      '{2'b01, 32'h1, 32'h0, 1'b1, 8'h64, 32'h3, 1'b0, 32'hD, 1'b1, 1'b0, 8'd4},
      // R10: write to unmapped 0x68 ignored
      '{2'b00, 32'h0, 32'h0, 1'b1, 8'h68, 32'hFFFF_FFFF, 1'b0, 32'hD, 1'b1, 1'b0, 8'd10},
      // R6: zero-mask raise on nonzero causes still pulses
      '{2'b10, 32'h0, 32'h0, 1'b0, 8'h00, 32'h0, 1'b1, 32'hD, 1'b1, 1'b1, 8'd6}
   };

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: state under reset
      check("R1 cause", cause, '0);
      check("R1 level", {31'b0, irq_level}, 32'h0);
      check("R1 pulse", {31'b0, msg_pulse}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 cause after release", cause, '0);

      for (int v = 0; v < NV; v++) begin
         src_raise = VEC[v].raise;
         src_mask  = {VEC[v].m1, VEC[v].m0};
         wr_en     = VEC[v].we;
         wr_addr   = VEC[v].wa;
         wr_data   = VEC[v].wd;
         msg_en    = VEC[v].msg;
         @(negedge clk);
         check($sformatf("R%0d cause v%0d", VEC[v].req, v), cause, VEC[v].ec);
         check($sformatf("R%0d level v%0d", VEC[v].req, v), {31'b0, irq_level}, {31'b0, VEC[v].el});
         check($sformatf("R%0d pulse v%0d", VEC[v].req, v), {31'b0, msg_pulse}, {31'b0, VEC[v].ep});
         check($sformatf("R5 read v%0d", v), rd_data, VEC[v].ec);
      end

      src_raise = '0;
      wr_en     = 1'b0;
      msg_en    = 1'b1;
      @(negedge clk);
      // R6: pulse of the last vector lasts one cycle only
      check("R6 pulse single", {31'b0, msg_pulse}, 32'h0);
      // R5: unmapped read offset returns all ones
      rd_addr = 8'h00;
      #1 check("R5 miss read", rd_data, 32'hFFFF_FFFF);
      rd_addr = 8'h24;
      #1 check("R5 cause read", rd_data, 32'hD);

      // R1: reset in mid-run clears pending causes and the line
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 midrun cause", cause, '0);
      check("R1 midrun level", {31'b0, irq_level}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 midrun after", cause, '0);
      summary();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
      end
   end

endmodule